// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block produces the word a host sees when it reads a flash array while an internal program or erase runs on its own timing. When idle, the array word passes straight through. When an operation is running, the word is replaced by a status pattern. Bit 7 carries a data-complement flag, bit 6 flips on each read access, and every other bit is zero. A host polls with ordinary reads until the true data appears again.

A small controller with three states follows the busy flag. `ST_IDLE` leaves on any clock edge where `busy` is high. It goes to `ST_ERASE` when `op_is_erase` is 1 and to `ST_PROG` when it is 0; this transition is called *start*. `ST_PROG` and `ST_ERASE` return to `ST_IDLE` on the first edge that samples `busy` low; this transition is called *finish*. There are no other transitions.

At *start*, two things happen. The bit 7 status value is captured: the complement of `prog_data[7]` for a program, 0 for an erase. The bit 6 toggle is also cleared. Rising edges of `rd_strobe` are detected against a registered copy of the strobe.

Top module: `opstat_reporter`

## Requirements
- R1: In `ST_IDLE`, `rd_data` equals `array_data` on every bit, in the same cycle.
- R2: In `ST_PROG`, `rd_data[7]` is the complement of `prog_data[7]` as sampled at the *start* edge.
- R3: In `ST_ERASE`, `rd_data[7]` is 0.
- R4: In `ST_PROG` or `ST_ERASE`, `rd_data[6]` inverts once for each 0-to-1 transition of `rd_strobe` sampled on a clock edge. A strobe held high counts once, and bit 6 is unchanged otherwise.
- R5: `rd_data[6]` is 0 in the first cycle of every run. This holds even when a strobe rising edge falls on the *start* edge.
- R6: In `ST_PROG` or `ST_ERASE`, every bit of `rd_data` other than bits 7 and 6 is 0, whatever `array_data` holds.
- R7: *start* and *finish* take effect at the clock edge that samples `busy` high in `ST_IDLE`, or low in a running state. `rd_data` changes form in the cycle after that edge, not before.
- R8: Changes to `op_is_erase` or `prog_data` during a run have no effect on `rd_data`.
- R9: While `rst_n` is low, the controller is in `ST_IDLE` and `rd_data` equals `array_data`. This takes effect at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_strobe | input | 1 | Read access strobe; a rising edge is one read |
| busy | input | 1 | High while an embedded operation runs |
| op_is_erase | input | 1 | Operation type at start: 1 erase, 0 program |
| prog_data | input | DATA_W | Word being programmed |
| array_data | input | DATA_W | True array word at the read address |
| rd_data | output | DATA_W | Word returned to the host |

## Verification
Two events can land on the same clock edge, and the bench forces each case on purpose. The first is a read-strobe rising edge on the *start* edge, where the toggle clear must win and the first status word shows bit 6 at 0. The second is a read-strobe rising edge on the *finish* edge, where the toggle advance is made but is never seen, because the next word is array data. A behavioural model in the bench decides the expected word for every cycle, and the output is compared against it on each falling clock edge.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } opstat_state_e;
endpackage

// File: rtl/opstat_edge.sv
module opstat_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/opstat_fsm.sv
module opstat_fsm
    import opstat_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          op_is_erase,
    output opstat_state_e state,
    output logic          start,
    output logic          running
);
    opstat_state_e state_q;
    opstat_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (busy) state_d = op_is_erase ? ST_ERASE : ST_PROG;
            ST_PROG:  if (!busy) state_d = ST_IDLE;
            ST_ERASE: if (!busy) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        start   = 1'b0;
        running = 1'b0;
        unique case (state_q)
            ST_IDLE:  start = busy;
            ST_PROG:  running = 1'b1;
            ST_ERASE: running = 1'b1;
            default:  running = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic tog
);
    logic tog_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tog_q <= 1'b0;
        else if (clear)   tog_q <= 1'b0;
        else if (advance) tog_q <= ~tog_q;
    end

    assign tog = tog_q;
endmodule

// File: rtl/opstat_compose.sv
module opstat_compose
    import opstat_pkg::*;
#(
    parameter int DW       = 16,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          cap_erase,
    input  logic          cap_bit,
    input  opstat_state_e state,
    input  logic          tog,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] rd_data
);
    logic          poll_q;
    logic [DW-1:0] status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       poll_q <= 1'b0;
        else if (capture) poll_q <= cap_erase ? 1'b0 : ~cap_bit;
    end

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i == POLL_BIT) begin : g_poll
            assign status[i] = poll_q;
        end else if (i == TOG_BIT) begin : g_tog
            assign status[i] = tog;
        end else begin : g_zero
            assign status[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  rd_data = array_data;
            ST_PROG:  rd_data = status;
            ST_ERASE: rd_data = status;
            default:  rd_data = array_data;
        endcase
    end
endmodule

// File: rtl/opstat_reporter.sv
module opstat_reporter
    import opstat_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              busy,
    input  logic              op_is_erase,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    opstat_state_e state_q;
    logic          start;
    logic          running;
    logic          rd_rise;
    logic          tog;

    opstat_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (rd_strobe),
        .rise   (rd_rise)
    );

    opstat_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .op_is_erase (op_is_erase),
        .state       (state_q),
        .start       (start),
        .running     (running)
    );

    opstat_toggle u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .advance (rd_rise & running),
        .tog     (tog)
    );

    opstat_compose #(
        .DW       (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_compose (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (start),
        .cap_erase  (op_is_erase),
        .cap_bit    (prog_data[POLL_BIT]),
        .state      (state_q),
        .tog        (tog),
        .array_data (array_data),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/opstat_reporter_chk.sv
module opstat_reporter_chk
    import opstat_pkg::*;
#(
    parameter int DW       = 16,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_strobe,
    input logic          busy,
    input logic          op_is_erase,
    input logic [DW-1:0] prog_data,
    input logic [DW-1:0] array_data,
    input logic [DW-1:0] rd_data,
    input opstat_state_e state
);
    localparam logic [DW-1:0] STAT_MASK = (DW'(1) << POLL_BIT) | (DW'(1) << TOG_BIT);

    logic run;
    assign run = (state != ST_IDLE);

    p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (rd_data == array_data));

    p_prog_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && $past(state) == ST_IDLE) |-> (rd_data[POLL_BIT] == !$past(prog_data[POLL_BIT])));

    p_erase_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE) |-> (rd_data[POLL_BIT] == 1'b0));

    p_tog_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(rd_strobe) && !$past(rd_strobe, 2)) |-> (rd_data[TOG_BIT] != $past(rd_data[TOG_BIT])));

    p_tog_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !($past(rd_strobe) && !$past(rd_strobe, 2))) |-> $stable(rd_data[TOG_BIT]));

    p_tog_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(state) == ST_IDLE) |-> (rd_data[TOG_BIT] == 1'b0));

    p_other_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((rd_data & ~STAT_MASK) == '0));

    p_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE && $past(busy)) |-> (state == ($past(op_is_erase) ? ST_ERASE : ST_PROG)));

    p_leave_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_IDLE && !$past(busy)) |-> (state == ST_IDLE));

    p_poll_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(rd_data[POLL_BIT]));
endmodule

bind opstat_reporter opstat_reporter_chk #(
    .DW       (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TOG_BIT  (TOG_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe   (rd_strobe),
    .busy        (busy),
    .op_is_erase (op_is_erase),
    .prog_data   (prog_data),
    .array_data  (array_data),
    .rd_data     (rd_data),
    .state       (state_q)
);

// File: tb/tb_opstat_reporter.sv
`timescale 1ns/100ps
module tb_opstat_reporter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_strobe = 1'b0;
    logic        busy = 1'b0;
    logic        op_is_erase = 1'b0;
    logic [15:0] prog_data = 16'h0000;
    logic [15:0] array_data = 16'hA5C3;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_err = 0;

    // behavioural reference: 0 idle, 1 program running, 2 erase running
    int   m_mode = 0;
    logic m_pbit = 1'b0;
    logic m_tog = 1'b0;
    logic m_prev = 1'b0;

    always #2.5 clk = ~clk;

    opstat_reporter dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_strobe   (rd_strobe),
        .busy        (busy),
        .op_is_erase (op_is_erase),
        .prog_data   (prog_data),
        .array_data  (array_data),
        .rd_data     (rd_data)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_tog = 1'b0; m_prev = 1'b0; m_pbit = 1'b0;
        end else begin
            if (m_mode == 0) begin
                if (busy) begin
                    m_mode = op_is_erase ? 2 : 1;
                    m_pbit = prog_data[7];
                    m_tog  = 1'b0;
                end
            end else begin
                if (rd_strobe && !m_prev) m_tog = ~m_tog;
                if (!busy) m_mode = 0;
            end
            m_prev = rd_strobe;
        end
    end

    function automatic logic [15:0] model_word();
        logic [15:0] w;
        if (m_mode == 0) return array_data;
        w = 16'h0000;
        w[7] = (m_mode == 1) ? ~m_pbit : 1'b0;
        w[6] = m_tog;
        return w;
    endfunction

    function automatic string model_tag();
        if (!rst_n)      return "R9";
        if (m_mode == 0) return "R1";
        if (m_mode == 1) return "R2/R4/R6";
        return "R3/R4/R6";
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk(model_tag(), rd_data, model_word());
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        step(); step();
        chk("R9 reset passthrough", rd_data, 16'hA5C3);
        rst_n = 1'b1;
        step();
        chk("R1 idle passthrough", rd_data, 16'hA5C3);

        // program run with data bit 7 = 1
        prog_data = 16'h0080; op_is_erase = 1'b0; busy = 1'b1;
        #1 chk("R7 no change before start edge", rd_data, 16'hA5C3);
        step();
        chk("R2/R5 program first word", rd_data, 16'h0000);
        prog_data = 16'h0000; op_is_erase = 1'b1; array_data = 16'hFFFF;
        rd_strobe = 1'b1; step();
        chk("R4/R8 first read edge", rd_data, 16'h0040);
        step();
        chk("R4 strobe held counts once", rd_data, 16'h0040);
        rd_strobe = 1'b0; step();
        chk("R4 strobe low no change", rd_data, 16'h0040);
        rd_strobe = 1'b1; step();
        chk("R4/R6 second read edge", rd_data, 16'h0000);
        rd_strobe = 1'b0; step();
        busy = 1'b0; rd_strobe = 1'b1;
        #1 chk("R7 status until finish edge", rd_data, 16'h0000);
        step();
        chk("R7 array after finish", rd_data, 16'hFFFF);
        rd_strobe = 1'b0; step();

        // erase run, read edge on start edge
        prog_data = 16'h0000; op_is_erase = 1'b1; busy = 1'b1; rd_strobe = 1'b1;
        array_data = 16'h1234;
        step();
        chk("R5/R3 erase first word", rd_data, 16'h0000);
        rd_strobe = 1'b0; step();
        rd_strobe = 1'b1; step();
        chk("R3/R4 erase toggled", rd_data, 16'h0040);
        rd_strobe = 1'b0; prog_data = 16'h0080; op_is_erase = 1'b0; step();
        chk("R8 erase ignores type change", rd_data, 16'h0040);
        busy = 1'b0; step();
        chk("R1 idle after erase", rd_data, 16'h1234);

        // program with bit 7 = 0, back-to-back runs
        prog_data = 16'h7F7F; op_is_erase = 1'b0; busy = 1'b1; step();
        chk("R2 program bit7 clear", rd_data, 16'h0080);
        rd_strobe = 1'b1; step();
        chk("R4 program toggled", rd_data, 16'h00C0);
        busy = 1'b0; step();
        busy = 1'b1; rd_strobe = 1'b0; prog_data = 16'hFFFF; step();
        chk("R5 toggle cleared on new run", rd_data, 16'h0000);

        // asynchronous reset in the middle of a run
        array_data = 16'h5A5A;
        rst_n = 1'b0;
        #1 chk("R9 async reset", rd_data, 16'h5A5A);
        busy = 1'b0; step();
        rst_n = 1'b1; step();

        for (int i = 0; i < 600; i++) begin
            rd_strobe   = 1'($urandom_range(0, 1));
            array_data  = 16'($urandom);
            prog_data   = 16'($urandom);
            op_is_erase = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 5) == 0) busy = ~busy;
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule